// File: doc/BRIEF.md
# DSP Coprocessor Host Register Port

This block is the byte-wide host bus side of a DSP coprocessor. A host CPU reaches three things through it: the 16-bit data register that carries words between host and DSP, the upper byte of the DSP status word, and a 2048 x 16-bit data RAM that it reads and writes one byte at a time. Before decoding, the host address is reduced with a fixed mask. Bits 23:20 and 18:16 drop out, so many host addresses alias onto the same target.

Host words pass through the data register one byte per strobe. A phase bit tracks which half comes next. In 16-bit mode the low byte moves first and the high byte second. In 8-bit mode only the low byte moves. A request flag signals that the DSP has placed a word, or wants one. The DSP sets it by loading the data register, and the host clears it with the access that finishes the transfer. Execution of DSP instructions lies outside this block. The block gives the DSP only a load port for the data register, a mode input and a read port into the data RAM.

Top module: `dsp_host_port`

## Requirements
- R1: After synchronous reset the data register, the phase bit (`drs`), the request flag (`rqm`) and `host_rdata` are all zero.
- R2: Decoding uses the host address ANDed with 0x08FFFF. Bits 23:20 and 18:16 never change which target is hit.
- R3: With `dsp_drc`=0 (16-bit mode), a host data-register access at masked address 0 moves the low byte and sets `drs` when `drs`=0. When `drs`=1 it moves the high byte and clears both `drs` and `rqm`.
- R4: With `dsp_drc`=1 (8-bit mode), each host data-register access moves only the low byte, clears `rqm` and leaves `drs` unchanged.
- R5: A read at masked address 1 returns the status high byte: bit 7 = `rqm`, bit 4 = `drs`, bit 2 = `dsp_drc`, and bits 6,5,3,1,0 taken from `dsp_status_hi`. Host writes to masked address 1 change nothing.
- R6: A `dsp_load` pulse loads `dsp_load_val` into the data register and sets `rqm`. If a host data-register access falls in the same cycle, the host access has no effect.
- R7: When masked bit 19 is set, the RAM word index is address bits 11:1. Address bit 0 selects the low (0) or the high (1) byte, and a read returns that byte.
- R8: A host RAM byte write leaves the other byte of the addressed word unchanged, as seen on the DSP RAM read port.
- R9: A read of any other masked address returns 0x00. A write there changes no state.
- R10: `host_rdata` is registered. It shows the read result in the cycle after the `host_rd` pulse and holds it until the next read. When `host_rd` and `host_wr` are both high, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 24 | Host byte address |
| host_rd | input | 1 | One-cycle host read strobe |
| host_wr | input | 1 | One-cycle host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| dsp_load | input | 1 | DSP loads the data register |
| dsp_load_val | input | 16 | Word the DSP loads |
| dsp_drc | input | 1 | Transfer width: 0 = 16-bit, 1 = 8-bit |
| dsp_status_hi | input | 8 | DSP-owned status bits for the host status byte |
| dsp_ram_addr | input | 11 | DSP RAM read word index |
| dsp_ram_rdata | output | 16 | DSP RAM read word |
| dr_out | output | 16 | Data register contents, seen by the DSP |
| rqm | output | 1 | Request flag |
| drs | output | 1 | Byte-phase bit |

## Verification
The hardest case to reach is a DSP load that lands in the same cycle as a host data-register access while `drs` is set mid-word. The bench hits this with a directed sequence: one low-byte access, then a load paired with a host access. It then checks that the phase and the register follow the load alone. The random phase toggles the width mode between accesses and reaches the data register and status byte through aliased addresses with random bits 23:20 and 18:16. This drives the sequencer through mode changes at either phase. RAM byte writes are checked through the DSP read port, so a lost neighbour byte shows up at once.

// File: rtl/dhp_pkg.sv
// Shared types for the DSP host register port.
// Assumes: status bit positions are fixed by the host software that decodes them.
package dhp_pkg;
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_DR   = 2'd1,
        TGT_SR   = 2'd2,
        TGT_RAM  = 2'd3
    } tgt_e;

    localparam int RQM_POS = 7;   // within the status high byte
    localparam int DRS_POS = 4;
    localparam int DRC_POS = 2;
    localparam logic [7:0] DSP_OWNED = 8'h6B;
endpackage

// File: rtl/dhp_decode.sv
// Host address decoder: masks the address and picks the target.
// Assumes: ADDR_MASK keeps RAM_SEL and bits RAM_AW:0.
module dhp_decode
    import dhp_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter logic [ADDR_W-1:0] ADDR_MASK = 24'h08FFFF,
    parameter int RAM_SEL = 19,
    parameter int RAM_AW = 11
) (
    input  logic [ADDR_W-1:0] addr,
    output tgt_e              tgt,
    output logic [RAM_AW-1:0] ram_word,
    output logic              ram_hi
);
    logic [ADDR_W-1:0] masked;

    // Reduce the address and classify it.
    always_comb begin
        masked   = addr & ADDR_MASK;
        ram_word = masked[RAM_AW:1];
        ram_hi   = masked[0];
        if (masked == '0)                 tgt = TGT_DR;
        else if (masked == ADDR_W'(1))    tgt = TGT_SR;
        else if (masked[RAM_SEL])         tgt = TGT_RAM;
        else                              tgt = TGT_NONE;
    end
endmodule

// File: rtl/dhp_dr_seq.sv
// Data register with byte-phase sequencer and request flag.
// Assumes: acc_rd and acc_wr are already qualified to the data register and never both high.
module dhp_dr_seq (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_rd,
    input  logic        acc_wr,
    input  logic [7:0]  wbyte,
    input  logic        drc,
    input  logic        dsp_load,
    input  logic [15:0] dsp_val,
    output logic [15:0] dr,
    output logic        drs,
    output logic        rqm,
    output logic [7:0]  rbyte
);
    logic acc;
    logic take_hi;

    // Decide which half the current access touches.
    always_comb begin
        acc     = acc_rd | acc_wr;
        take_hi = !drc && drs;
        rbyte   = take_hi ? dr[15:8] : dr[7:0];
    end

    // Register, phase and request updates; DSP load wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr  <= '0;
            drs <= 1'b0;
            rqm <= 1'b0;
        end else if (dsp_load) begin
            dr  <= dsp_val;
            rqm <= 1'b1;
        end else if (acc) begin
            if (drc) begin
                rqm <= 1'b0;
                if (acc_wr) dr[7:0] <= wbyte;
            end else if (!drs) begin
                drs <= 1'b1;
                if (acc_wr) dr[7:0] <= wbyte;
            end else begin
                drs <= 1'b0;
                rqm <= 1'b0;
                if (acc_wr) dr[15:8] <= wbyte;
            end
        end
    end
endmodule

// File: rtl/dhp_ram.sv
// Byte-lane data RAM: host byte writes, host and DSP word reads.
// Assumes: one lane per byte so a write never touches the neighbour byte.
module dhp_ram #(
    parameter int WORDS = 2048,
    parameter int LANES = 2,
    localparam int AW = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     h_addr,
    input  logic              h_hi,
    input  logic [7:0]        wbyte,
    output logic [8*LANES-1:0] h_rdata,
    input  logic [AW-1:0]     d_addr,
    output logic [8*LANES-1:0] d_rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] mem [WORDS];

        // Write this lane when the byte select points at it.
        always_ff @(posedge clk) begin
            if (we && (int'(h_hi) == g)) mem[h_addr] <= wbyte;
        end

        // Asynchronous read for both ports.
        always_comb begin
            h_rdata[g*8 +: 8] = mem[h_addr];
            d_rdata[g*8 +: 8] = mem[d_addr];
        end
    end
endmodule

// File: rtl/dsp_host_port.sv
// Host-side register port of a DSP coprocessor: data register, status byte, data RAM.
// Assumes: host strobes are one-cycle pulses; a write wins over a read in the same cycle.
module dsp_host_port
    import dhp_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int RAM_WORDS = 2048,
    localparam int RAM_AW = $clog2(RAM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              dsp_load,
    input  logic [15:0]       dsp_load_val,
    input  logic              dsp_drc,
    input  logic [7:0]        dsp_status_hi,
    input  logic [RAM_AW-1:0] dsp_ram_addr,
    output logic [15:0]       dsp_ram_rdata,
    output logic [15:0]       dr_out,
    output logic              rqm,
    output logic              drs
);
    tgt_e              tgt;
    logic [RAM_AW-1:0] ram_word;
    logic              ram_hi;
    logic              rd_eff;
    logic              hit_dr, hit_sr, hit_none;
    logic [7:0]        dr_byte;
    logic [7:0]        sr_byte;
    logic [15:0]       ram_word_q;
    logic [7:0]        rd_mux;

    dhp_decode #(
        .ADDR_W   (ADDR_W),
        .ADDR_MASK(ADDR_W'(24'h08FFFF)),
        .RAM_SEL  (19),
        .RAM_AW   (RAM_AW)
    ) u_dec (
        .addr    (host_addr),
        .tgt     (tgt),
        .ram_word(ram_word),
        .ram_hi  (ram_hi)
    );

    // Qualify strobes per target.
    always_comb begin
        rd_eff   = host_rd && !host_wr;
        hit_dr   = (tgt == TGT_DR);
        hit_sr   = (tgt == TGT_SR);
        hit_none = (tgt == TGT_NONE);
    end

    dhp_dr_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_rd  (rd_eff && hit_dr),
        .acc_wr  (host_wr && hit_dr),
        .wbyte   (host_wdata),
        .drc     (dsp_drc),
        .dsp_load(dsp_load),
        .dsp_val (dsp_load_val),
        .dr      (dr_out),
        .drs     (drs),
        .rqm     (rqm),
        .rbyte   (dr_byte)
    );

    dhp_ram #(.WORDS(RAM_WORDS), .LANES(2)) u_ram (
        .clk    (clk),
        .we     (host_wr && (tgt == TGT_RAM)),
        .h_addr (ram_word),
        .h_hi   (ram_hi),
        .wbyte  (host_wdata),
        .h_rdata(ram_word_q),
        .d_addr (dsp_ram_addr),
        .d_rdata(dsp_ram_rdata)
    );

    // Build the status byte and select the read source.
    always_comb begin
        sr_byte = (dsp_status_hi & DSP_OWNED);
        sr_byte[RQM_POS] = rqm;
        sr_byte[DRS_POS] = drs;
        sr_byte[DRC_POS] = dsp_drc;
        unique case (tgt)
            TGT_DR:  rd_mux = dr_byte;
            TGT_SR:  rd_mux = sr_byte;
            TGT_RAM: rd_mux = ram_hi ? ram_word_q[15:8] : ram_word_q[7:0];
            default: rd_mux = 8'h00;
        endcase
    end

    // Capture read data on an effective read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      host_rdata <= 8'h00;
        else if (rd_eff) host_rdata <= rd_mux;
    end
endmodule

// File: rtl/dsp_host_port_chk.sv
// Temporal checks on the host port, bound into the top module.
module dsp_host_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_rd,
    input logic        host_wr,
    input logic        hit_dr,
    input logic        hit_sr,
    input logic        hit_none,
    input logic        dsp_load,
    input logic        dsp_drc,
    input logic        rqm,
    input logic        drs,
    input logic [15:0] dr_out,
    input logic [7:0]  host_rdata
);
    // R6
    load_sets_rqm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_load |=> rqm);
    // R4
    narrow_clears_rqm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_dr && (host_rd || host_wr) && dsp_drc && !dsp_load) |=> (!rqm && $stable(drs)));
    // R3
    first_byte_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_dr && (host_rd || host_wr) && !dsp_drc && !drs && !dsp_load) |=> (drs && $stable(rqm)));
    // R3
    second_byte_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_dr && (host_rd || host_wr) && !dsp_drc && drs && !dsp_load) |=> (!drs && !rqm));
    // R5
    status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hit_sr && !dsp_load) |=> ($stable(dr_out) && $stable(rqm) && $stable(drs)));
    // R9
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && hit_none) |=> (host_rdata == 8'h00));
endmodule

bind dsp_host_port dsp_host_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .hit_dr    (hit_dr),
    .hit_sr    (hit_sr),
    .hit_none  (hit_none),
    .dsp_load  (dsp_load),
    .dsp_drc   (dsp_drc),
    .rqm       (rqm),
    .drs       (drs),
    .dr_out    (dr_out),
    .host_rdata(host_rdata)
);

// File: tb/sim_dsp_host_port.sv
module sim_dsp_host_port;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] host_addr = '0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        dsp_load = 1'b0;
    logic [15:0] dsp_load_val = '0;
    logic        dsp_drc = 1'b0;
    logic [7:0]  dsp_status_hi = '0;
    logic [10:0] dsp_ram_addr = '0;
    logic [15:0] dsp_ram_rdata;
    logic [15:0] dr_out;
    logic        rqm, drs;

    dsp_host_port u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, failures = 0;
    logic [15:0] m_dr;
    logic        m_drs, m_rqm;
    logic [7:0]  m_lo [WORDS];
    logic [7:0]  m_hi [WORDS];
    bit          k_lo [WORDS];
    bit          k_hi [WORDS];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // 0 none, 1 data register, 2 status, 3 RAM
    function automatic int mdec(input logic [23:0] a);
        logic [23:0] m;
        m = a & 24'h08FFFF;
        if (m == 0) return 1;
        if (m == 1) return 2;
        if (m[19]) return 3;
        return 0;
    endfunction

    function automatic logic [7:0] exp_status();
        logic [7:0] s;
        s = dsp_status_hi & 8'h6B;
        s[7] = m_rqm; s[4] = m_drs; s[2] = dsp_drc;
        return s;
    endfunction

    task automatic check_state(input string req);
        chk(rqm === m_rqm, req, "rqm", rqm, m_rqm);
        chk(drs === m_drs, req, "drs", drs, m_drs);
        chk(dr_out === m_dr, req, "dr_out", dr_out, m_dr);
    endtask

    // One host access, optionally with a same-cycle DSP load.
    task automatic access(input bit wr, input logic [23:0] a, input logic [7:0] wd,
                          input bit ld, input logic [15:0] lv, input string req);
        int t;
        logic [7:0] exp_rd;
        bit rd_known;
        logic [10:0] w;
        t = mdec(a);
        w = a[11:1];
        rd_known = 1;
        exp_rd = 8'h00;
        if (!wr) begin
            case (t)
                1: exp_rd = (!dsp_drc && m_drs) ? m_dr[15:8] : m_dr[7:0];
                2: exp_rd = exp_status();
                3: begin
                    rd_known = a[0] ? k_hi[w] : k_lo[w];
                    exp_rd = a[0] ? m_hi[w] : m_lo[w];
                end
                default: exp_rd = 8'h00;
            endcase
        end
        @(negedge clk);
        host_addr = a; host_wdata = wd; host_wr = wr; host_rd = !wr;
        dsp_load = ld; dsp_load_val = lv;
        @(negedge clk);
        host_wr = 0; host_rd = 0; dsp_load = 0;
        if (ld) begin
            m_dr = lv; m_rqm = 1;
        end else if (t == 1) begin
            if (dsp_drc) begin
                m_rqm = 0;
                if (wr) m_dr[7:0] = wd;
            end else if (!m_drs) begin
                m_drs = 1;
                if (wr) m_dr[7:0] = wd;
            end else begin
                m_drs = 0; m_rqm = 0;
                if (wr) m_dr[15:8] = wd;
            end
        end
        if (wr && t == 3) begin
            if (a[0]) begin m_hi[w] = wd; k_hi[w] = 1; end
            else begin m_lo[w] = wd; k_lo[w] = 1; end
        end
        if (!wr && rd_known)
            chk(host_rdata === exp_rd, req, "host_rdata", host_rdata, exp_rd);
        check_state(req);
    endtask

    task automatic dload(input logic [15:0] v);
        @(negedge clk);
        dsp_load = 1; dsp_load_val = v;
        @(negedge clk);
        dsp_load = 0;
        m_dr = v; m_rqm = 1;
        check_state("R6");
    endtask

    task automatic ram_peek(input logic [10:0] w, input string req);
        dsp_ram_addr = w;
        #1;
        if (k_lo[w]) chk(dsp_ram_rdata[7:0] === m_lo[w], req, "ram lo", dsp_ram_rdata[7:0], m_lo[w]);
        if (k_hi[w]) chk(dsp_ram_rdata[15:8] === m_hi[w], req, "ram hi", dsp_ram_rdata[15:8], m_hi[w]);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] prev;
        void'($urandom(32'd4242));
        m_dr = 0; m_drs = 0; m_rqm = 0;
        for (int i = 0; i < WORDS; i++) begin k_lo[i] = 0; k_hi[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check_state("R1");
        chk(host_rdata === 8'h00, "R1", "host_rdata", host_rdata, 0);

        // R3 16-bit write then read via aliases (R2)
        dsp_drc = 0;
        dload(16'hA55A);
        access(1, 24'hF00000, 8'h34, 0, 0, "R3");
        access(1, 24'h070000, 8'h12, 0, 0, "R3");
        access(0, 24'h000000, 0, 0, 0, "R2");
        access(0, 24'h350000, 0, 0, 0, "R2");
        // R4 8-bit mode
        dsp_drc = 1;
        dload(16'hBEEF);
        access(0, 24'h000000, 0, 0, 0, "R4");
        access(1, 24'h000000, 8'h77, 0, 0, "R4");
        // R5 status read and ignored write
        dsp_status_hi = 8'hFF;
        access(0, 24'h000001, 0, 0, 0, "R5");
        access(1, 24'hA60001, 8'hFF, 0, 0, "R5");
        access(0, 24'h000001, 0, 0, 0, "R5");
        // R6 load colliding with second-phase access
        dsp_drc = 0;
        access(0, 24'h000000, 0, 0, 0, "R6");
        access(1, 24'h000000, 8'h99, 1, 16'h1357, "R6");
        access(0, 24'h000000, 0, 0, 0, "R6");
        // R7/R8 RAM bytes, neighbour preserved
        access(1, 24'h080010, 8'hC3, 0, 0, "R8");
        access(1, 24'h080011, 8'h3C, 0, 0, "R8");
        access(1, 24'h080010, 8'h5A, 0, 0, "R8");
        ram_peek(11'h008, "R8");
        access(0, 24'hF90011, 0, 0, 0, "R7");
        access(0, 24'h08FFFF, 0, 0, 0, "R7");
        // R9 unmapped
        access(1, 24'h000002, 8'hEE, 0, 0, "R9");
        access(0, 24'h04ABCD, 0, 0, 0, "R9");
        // R10 hold and write-wins
        prev = host_rdata;
        repeat (3) @(negedge clk);
        chk(host_rdata === prev, "R10", "hold", host_rdata, prev);
        @(negedge clk);
        host_addr = 24'h000001; host_rd = 1; host_wr = 1; host_wdata = 8'h00;
        @(negedge clk);
        host_rd = 0; host_wr = 0;
        chk(host_rdata === prev, "R10", "write wins", host_rdata, prev);

        // Random phase
        for (int i = 0; i < 5000; i++) begin
            int r;
            logic [23:0] a;
            bit wr;
            r = $urandom % 10;
            wr = $urandom % 2;
            a = '0;
            case (r)
                0: dload(16'($urandom));
                1: dsp_drc = $urandom % 2;
                2, 3: begin
                    a = {4'($urandom), 1'b0, 3'($urandom), 16'h0000};
                    access(wr, a, 8'($urandom), 0, 0, "R3");
                end
                4: begin
                    dsp_status_hi = 8'($urandom);
                    a = {4'($urandom), 1'b0, 3'($urandom), 16'h0001};
                    access(wr, a, 8'($urandom), 0, 0, "R5");
                end
                5, 6, 7: begin
                    a = {4'($urandom), 1'b1, 3'($urandom), 4'($urandom), 1'b0, 7'($urandom), 1'($urandom)};
                    access(wr, a, 8'($urandom), 0, 0, "R7");
                    if (wr) ram_peek(a[11:1], "R8");
                end
                default: begin
                    a = {4'($urandom), 1'b0, 3'($urandom), 16'(2 + ($urandom % 16'hFFFE))};
                    access(wr, a, 8'($urandom), 0, 0, "R9");
                end
            endcase
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule